// File: doc/BRIEF.md
# SDRAM Request Splitter and Address Decoder

This block sits between an application port and a downstream SDRAM bank controller. It takes one transfer request: a start address and a length, both counted in 16-bit words, a direction, a wrap flag and a request tag. It turns that request into a series of sub-requests, each confined to a single SDRAM page.

Every sub-request carries the bank, row and column fields decoded from its own start address, a length in SDRAM beats, and markers for the first and the final piece. Two configuration inputs control the decode. One selects the SDRAM data width (32, 16 or 8 bits), and this scales both the address and the length. The other selects the column width (8 to 11 bits), which places the bank and row fields.

A request in wrap mode is never split. It goes downstream as a single 4-beat sub-request. The application side is acknowledged when the request is captured. Sub-requests advance on the downstream acknowledge, and no new request is taken until the final piece of the current one has been acknowledged. The configuration inputs must stay stable while a request is in progress.

Top module: `sdsplit_top`

## Requirements
- R1: Data width select `cfg_dw_sel` (2'b00 = 32-bit, 2'b01 = 16-bit, 2'b10/2'b11 = 8-bit) converts the 16-bit-word address to a beat address (addr>>1, addr, addr<<1) and the length to a beat count (ceil(len/2), len, 2*len); the request length must be at least 1.
- R2: Column select `cfg_col_sel` gives CB = 8 + code column bits; from the beat address the column is bits [CB-1:0], the bank the next 2 bits [CB+1:CB], the row the next 13 bits [CB+14:CB+2]; column and row leave as 13-bit values, zero-extended.
- R3: Without wrap, each sub-request has a nonzero length and column + length never exceeds 2^CB; the lengths of all pieces add up to the beat count of R1.
- R4: Each sub-request after the first starts at the beat address just past the previous piece, so its column is 0.
- R5: A wrap request produces exactly one sub-request, length 4, decoded from the start address, with both first and final set.
- R6: `sub_first` is set only on the first piece and `sub_final` only on the last piece; an unsplit request carries both.
- R7: `req_ack` is high, in the same cycle, exactly when `req_valid` is high and no request is in progress; `sub_valid` rises on the next clock edge; after the final piece is acknowledged, `sub_valid` falls.
- R8: While `sub_valid` is high and `sub_ack` is low, all sub-request outputs hold their values.
- R9: `sub_tag`, `sub_write` and `sub_wrap` reproduce the captured request's tag, direction and wrap flag on every piece.
- R10: After reset, `sub_valid` is low and `req_ack` is low while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dw_sel | input | 2 | SDRAM data width select |
| cfg_col_sel | input | 2 | Column width select |
| req_valid | input | 1 | Application request present |
| req_tag | input | TW | Request tag |
| req_addr | input | AW | Start address in 16-bit words |
| req_len | input | LW | Length in 16-bit words |
| req_wrap | input | 1 | Wrap mode, fixed 4-beat transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ack | output | 1 | Request captured |
| sub_valid | output | 1 | Sub-request present |
| sub_ack | input | 1 | Downstream accepts sub-request |
| sub_first | output | 1 | First piece of the request |
| sub_final | output | 1 | Last piece of the request |
| sub_wrap | output | 1 | Wrap flag of the request |
| sub_write | output | 1 | Direction of the request |
| sub_tag | output | TW | Tag of the request |
| sub_bank | output | 2 | Bank field |
| sub_row | output | 13 | Row field |
| sub_col | output | 13 | Column field |
| sub_len | output | CW | Piece length in beats |

## Verification
The sweep covers every data width and every column width, with start columns at 0, 1, one and two beats before the page end, and mid-page. Lengths run from a single word to more than two pages. This exercises the cases a faulty design would get wrong:
- an off-by-one room computation would let a piece run one beat into the next page, or would leave a zero-length piece;
- a wrong shift for the data width would misplace the bank and row fields;
- a wrong rounding would lose the odd trailing word of a 32-bit transfer.

Wrap requests placed near the page end check that they stay whole and are not chopped. Random stalls on the downstream side, together with a second request raised during a transfer, check that a design does not advance on a stall or accept a request while busy.

// File: rtl/sdsplit_pkg.sv
package sdsplit_pkg;

  typedef enum logic [0:0] {
    SPL_IDLE = 1'b0,
    SPL_BUSY = 1'b1
  } spl_state_e;

  localparam logic [1:0] DWSEL_32 = 2'b00;
  localparam logic [1:0] DWSEL_16 = 2'b01;

  localparam int unsigned COLBITS_MIN = 8;
  localparam int unsigned BANK_W      = 2;
  localparam int unsigned ROW_W       = 13;
  localparam int unsigned COL_W       = 13;
  localparam int unsigned WRAP_BEATS  = 4;

  // number of column bits selected by the 2-bit code
  function automatic logic [3:0] col_bits(input logic [1:0] sel);
    return 4'(COLBITS_MIN) + {2'b00, sel};
  endfunction

endpackage

// File: rtl/sdsplit_conv.sv
// Converts a 16-bit-word address and length to SDRAM beat units.
module sdsplit_conv
  import sdsplit_pkg::*;
#(
  parameter int AW  = 26,
  parameter int LW  = 12,
  parameter int BAW = AW + 1,
  parameter int CW  = 14
) (
  input  logic [1:0]     dw_sel,
  input  logic [AW-1:0]  addr,
  input  logic [LW-1:0]  len,
  input  logic           wrap,
  output logic [BAW-1:0] beat,
  output logic [CW-1:0]  cnt
);

  logic [LW:0] len_ext;
  assign len_ext = {1'b0, len};

  always_comb begin
    if (dw_sel == DWSEL_32) begin
      beat = BAW'(addr >> 1);
      cnt  = CW'((len_ext + (LW+1)'(1)) >> 1);
    end else if (dw_sel == DWSEL_16) begin
      beat = BAW'(addr);
      cnt  = CW'(len);
    end else begin
      beat = BAW'({addr, 1'b0});
      cnt  = CW'({len, 1'b0});
    end
    if (wrap) begin
      cnt = CW'(WRAP_BEATS);
    end
  end

endmodule

// File: rtl/sdsplit_fields.sv
// Splits a beat address into column, bank and row; reports room left in page.
module sdsplit_fields
  import sdsplit_pkg::*;
#(
  parameter int BAW = 27,
  parameter int CW  = 14
) (
  input  logic [BAW-1:0]    beat,
  input  logic [1:0]        col_sel,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [CW-1:0]     room
);

  localparam int EXTW = BAW + ROW_W + BANK_W;
  localparam int RBW  = ROW_W + BANK_W;

  logic [3:0]      cb;
  logic [EXTW-1:0] ext;
  logic [RBW-1:0]  upper;
  logic [CW-1:0]   page;
  logic [BAW-1:0]  col_full;

  always_comb begin
    cb       = col_bits(col_sel);
    ext      = EXTW'(beat);
    upper    = RBW'(ext >> cb);
    bank     = upper[BANK_W-1:0];
    row      = upper[RBW-1:BANK_W];
    page     = CW'(1) << cb;
    col_full = beat & (BAW'(page) - BAW'(1));
    col      = COL_W'(col_full);
    room     = page - CW'(col_full);
  end

endmodule

// File: rtl/sdsplit_ctrl.sv
// Request capture, piece sequencing and downstream handshake.
module sdsplit_ctrl
  import sdsplit_pkg::*;
#(
  parameter int TW  = 4,
  parameter int BAW = 27,
  parameter int CW  = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [TW-1:0]  req_tag,
  input  logic           req_write,
  input  logic           req_wrap,
  input  logic [1:0]     col_sel_in,
  input  logic [BAW-1:0] beat_in,
  input  logic [CW-1:0]  cnt_in,
  input  logic [CW-1:0]  room,
  input  logic           sub_ack,
  output logic           req_ack,
  output logic           sub_valid,
  output logic           sub_first,
  output logic           sub_final,
  output logic           sub_wrap,
  output logic           sub_write,
  output logic [TW-1:0]  sub_tag,
  output logic [1:0]     col_sel_q,
  output logic [BAW-1:0] cur_beat,
  output logic [CW-1:0]  sub_len
);

  spl_state_e     state_q, state_d;
  logic [BAW-1:0] beat_q, beat_d;
  logic [CW-1:0]  rem_q, rem_d;
  logic           first_q, first_d;
  logic           wrap_q, write_q;
  logic [TW-1:0]  tag_q;
  logic [1:0]     csel_q;
  logic           fits, load_en, step_en;

  // next-state logic
  always_comb begin
    fits      = (rem_q <= room);
    sub_len   = wrap_q ? CW'(WRAP_BEATS) : (fits ? rem_q : room);
    sub_final = wrap_q | fits;
    load_en   = (state_q == SPL_IDLE) & req_valid;
    step_en   = (state_q == SPL_BUSY) & sub_ack & ~sub_final;

    state_d = state_q;
    case (state_q)
      SPL_IDLE: if (load_en) state_d = SPL_BUSY;
      SPL_BUSY: if (sub_ack && sub_final) state_d = SPL_IDLE;
      default:  state_d = SPL_IDLE;
    endcase

    beat_d  = load_en ? beat_in : beat_q + BAW'(sub_len);
    rem_d   = load_en ? cnt_in  : rem_q - sub_len;
    first_d = load_en;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPL_IDLE;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_en || step_en) first_q <= first_d;
    end
  end

  // data registers, enabled only
  always_ff @(posedge clk) begin
    if (load_en || step_en) begin
      beat_q <= beat_d;
      rem_q  <= rem_d;
    end
    if (load_en) begin
      wrap_q  <= req_wrap;
      write_q <= req_write;
      tag_q   <= req_tag;
      csel_q  <= col_sel_in;
    end
  end

  assign req_ack   = load_en;
  assign sub_valid = (state_q == SPL_BUSY);
  assign sub_first = first_q;
  assign sub_wrap  = wrap_q;
  assign sub_write = write_q;
  assign sub_tag   = tag_q;
  assign col_sel_q = csel_q;
  assign cur_beat  = beat_q;

endmodule

// File: rtl/sdsplit_top.sv
module sdsplit_top
  import sdsplit_pkg::*;
#(
  parameter int AW = 26,
  parameter int LW = 12,
  parameter int TW = 4,
  localparam int BAW = AW + 1,
  localparam int CW  = ((LW + 2) > 12) ? (LW + 2) : 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_dw_sel,
  input  logic [1:0]    cfg_col_sel,
  input  logic          req_valid,
  input  logic [TW-1:0] req_tag,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_wrap,
  input  logic          req_write,
  output logic          req_ack,
  output logic          sub_valid,
  input  logic          sub_ack,
  output logic          sub_first,
  output logic          sub_final,
  output logic          sub_wrap,
  output logic          sub_write,
  output logic [TW-1:0] sub_tag,
  output logic [1:0]    sub_bank,
  output logic [12:0]   sub_row,
  output logic [12:0]   sub_col,
  output logic [CW-1:0] sub_len
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [BAW-1:0] beat_in, cur_beat;
  logic [CW-1:0]  cnt_in, room;
  logic [1:0]     col_sel_q;

  sdsplit_conv #(.AW(AW), .LW(LW), .BAW(BAW), .CW(CW)) u_conv (
    .dw_sel (cfg_dw_sel),
    .addr   (req_addr),
    .len    (req_len),
    .wrap   (req_wrap),
    .beat   (beat_in),
    .cnt    (cnt_in)
  );

  sdsplit_ctrl #(.TW(TW), .BAW(BAW), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_tag    (req_tag),
    .req_write  (req_write),
    .req_wrap   (req_wrap),
    .col_sel_in (cfg_col_sel),
    .beat_in    (beat_in),
    .cnt_in     (cnt_in),
    .room       (room),
    .sub_ack    (sub_ack),
    .req_ack    (req_ack),
    .sub_valid  (sub_valid),
    .sub_first  (sub_first),
    .sub_final  (sub_final),
    .sub_wrap   (sub_wrap),
    .sub_write  (sub_write),
    .sub_tag    (sub_tag),
    .col_sel_q  (col_sel_q),
    .cur_beat   (cur_beat),
    .sub_len    (sub_len)
  );

  sdsplit_fields #(.BAW(BAW), .CW(CW)) u_fields (
    .beat    (cur_beat),
    .col_sel (col_sel_q),
    .bank    (sub_bank),
    .row     (sub_row),
    .col     (sub_col),
    .room    (room)
  );

endmodule

// File: rtl/sdsplit_chk.sv
module sdsplit_chk #(
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_col_sel,
  input logic          req_ack,
  input logic          sub_valid,
  input logic          sub_ack,
  input logic          sub_first,
  input logic          sub_final,
  input logic          sub_wrap,
  input logic [1:0]    sub_bank,
  input logic [12:0]   sub_row,
  input logic [12:0]   sub_col,
  input logic [CW-1:0] sub_len
);

  logic [CW+1:0] lim, reach;
  always_comb begin
    lim   = (CW+2)'(1) << (4'd8 + {2'b00, cfg_col_sel});
    reach = (CW+2)'(sub_col) + (CW+2)'(sub_len);
  end

  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !sub_valid);

  assert_ack_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> sub_valid && sub_first);

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ack && sub_final |=> !sub_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ack |=> sub_valid && $stable(sub_col) && $stable(sub_row)
      && $stable(sub_bank) && $stable(sub_len) && $stable(sub_first) && $stable(sub_final));

  assert_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_wrap |-> (sub_len != '0) && (reach <= lim));

  assert_wrap_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_wrap |-> (sub_len == CW'(4)) && sub_first && sub_final);

  assert_resume_col0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ack && !sub_final |=> sub_valid && !sub_first && (sub_col == 13'd0));

endmodule

bind sdsplit_top sdsplit_chk #(.CW(CW)) u_sdsplit_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .cfg_col_sel (cfg_col_sel),
  .req_ack     (req_ack),
  .sub_valid   (sub_valid),
  .sub_ack     (sub_ack),
  .sub_first   (sub_first),
  .sub_final   (sub_final),
  .sub_wrap    (sub_wrap),
  .sub_bank    (sub_bank),
  .sub_row     (sub_row),
  .sub_col     (sub_col),
  .sub_len     (sub_len)
);

// File: tb/test_sdsplit_top.sv
`timescale 1ns/1ps
module test_sdsplit_top;

  localparam int AW = 26;
  localparam int LW = 12;
  localparam int TW = 4;
  localparam int CW = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_dw_sel, cfg_col_sel;
  logic          req_valid, req_wrap, req_write, req_ack;
  logic [TW-1:0] req_tag;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          sub_valid, sub_ack, sub_first, sub_final, sub_wrap, sub_write;
  logic [TW-1:0] sub_tag;
  logic [1:0]    sub_bank;
  logic [12:0]   sub_row, sub_col;
  logic [CW-1:0] sub_len;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  sdsplit_top #(.AW(AW), .LW(LW), .TW(TW)) i_sdsplit_top (
    .clk(clk), .rst_n(rst_n), .cfg_dw_sel(cfg_dw_sel), .cfg_col_sel(cfg_col_sel),
    .req_valid(req_valid), .req_tag(req_tag), .req_addr(req_addr), .req_len(req_len),
    .req_wrap(req_wrap), .req_write(req_write), .req_ack(req_ack),
    .sub_valid(sub_valid), .sub_ack(sub_ack), .sub_first(sub_first), .sub_final(sub_final),
    .sub_wrap(sub_wrap), .sub_write(sub_write), .sub_tag(sub_tag), .sub_bank(sub_bank),
    .sub_row(sub_row), .sub_col(sub_col), .sub_len(sub_len)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // checks the presented sub-request against expected values
  task automatic chk_sub(input longint eb, input longint el, input bit ef, input bit efin,
                         input int cb, input bit w, input bit wr, input int tg);
    longint ecol, ebank, erow;
    ecol  = eb & ((64'd1 << cb) - 1);
    ebank = (eb >> cb) & 3;
    erow  = (eb >> (cb + 2)) & 8191;
    chk(sub_valid == 1'b1, "R7 valid", sub_valid, 1);
    chk(sub_col == 13'(ecol), "R2 col", sub_col, ecol);
    chk(sub_bank == 2'(ebank), "R2 bank", sub_bank, ebank);
    chk(sub_row == 13'(erow), "R2 row", sub_row, erow);
    chk(sub_len == CW'(el), w ? "R5 len" : "R3 len", sub_len, el);
    chk(sub_first == ef, "R6 first", sub_first, ef);
    chk(sub_final == efin, "R6 final", sub_final, efin);
    chk(sub_wrap == w && sub_write == wr && sub_tag == TW'(tg), "R9 attrs",
        {sub_wrap, sub_write, sub_tag}, {w, wr, 4'(tg)});
  endtask

  task automatic do_req(input int dw, input int cs, input longint addr, input longint len,
                        input bit w, input bit wr, input int tg);
    longint beat, rem, room, n, page;
    int cb, k;
    bit first, fin;
    cb   = 8 + cs;
    page = 64'd1 << cb;
    // R1: conversion to beat units
    if (dw == 0) begin beat = addr >> 1; rem = (len + 1) >> 1; end
    else if (dw == 1) begin beat = addr; rem = len; end
    else begin beat = addr << 1; rem = len * 2; end
    @(negedge clk);
    cfg_dw_sel = 2'(dw); cfg_col_sel = 2'(cs);
    req_addr = AW'(addr); req_len = LW'(len); req_wrap = w; req_write = wr; req_tag = TW'(tg);
    req_valid = 1'b1;
    #1 chk(req_ack == 1'b1, "R7 ack", req_ack, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first = 1'b1; k = 0; fin = 1'b0;
    while (!fin) begin
      room = page - (beat & (page - 1));
      if (w) begin n = 4; fin = 1'b1; end
      else begin n = (rem <= room) ? rem : room; fin = (rem <= room); end
      chk_sub(beat, n, first, fin, cb, w, wr, tg);
      if (first) begin
        req_valid = 1'b1;
        #1 chk(req_ack == 1'b0, "R7 busy", req_ack, 0);
        req_valid = 1'b0;
      end
      repeat ((k + tg) % 3) begin
        @(negedge clk);
        chk_sub(beat, n, first, fin, cb, w, wr, tg); // R8 hold under stall
      end
      sub_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sub_ack = 1'b0;
      beat = beat + n; rem = rem - n; first = 1'b0; k++;
    end
    chk(sub_valid == 1'b0, "R7 drop", sub_valid, 0);
    if (!w) chk(rem == 0, "R3 total", rem, 0);
  endtask

  initial begin
    int idx;
    rst_n = 1'b0; req_valid = 1'b0; sub_ack = 1'b0;
    cfg_dw_sel = 2'b01; cfg_col_sel = 2'b00;
    req_tag = '0; req_addr = '0; req_len = '0; req_wrap = 1'b0; req_write = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sub_valid == 1'b0, "R10 valid", sub_valid, 0);
    chk(req_ack == 1'b0, "R10 ack", req_ack, 0);
    idx = 0;
    for (int dw = 0; dw < 3; dw++) begin
      for (int cs = 0; cs < 4; cs++) begin
        for (int oi = 0; oi < 5; oi++) begin
          for (int li = 0; li < 6; li++) begin
            longint page, o, bt, addr, len, row, bank;
            bit w;
            page = 64'd1 << (8 + cs);
            case (oi)
              0: o = 0;
              1: o = 1;
              2: o = page - 1;
              3: o = page - 2;
              default: o = page / 2 + 3;
            endcase
            case (li)
              0: len = 1;
              1: len = 2;
              2: len = 5;
              3: len = page;
              4: len = page + 3;
              default: len = 2 * page + 1;
            endcase
            if (len > 4095) len = 4095;
            row  = (idx * 37) & 1023;
            bank = idx & 3;
            bt   = (row << (8 + cs + 2)) | (bank << (8 + cs)) | o;
            if (dw == 0)      addr = bt * 2 + (idx & 1);
            else if (dw == 1) addr = bt;
            else              addr = bt / 2;
            w = (idx % 5 == 0);
            do_req(dw, cs, addr, len, w, idx[0], idx & 15);
            idx++;
          end
        end
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule